// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for a synchronous memory that serves four-beat bursts. A cycle with the advance/load input low and the chip selected captures a new base address and the read/write direction of the burst. Each later cycle with advance high steps a two-bit beat counter. The two least significant address bits are then derived from the captured start offset and that counter. The upper address bits stay as they were captured.

Two beat orders are supported from any start offset, and a static mode input picks one. In interleaved order the beat count is XORed into the start offset. In linear order the beat count is added to it modulo four. After four beats the sequence returns to its start and keeps repeating for as long as advance stays high. A deselect on a load cycle ends the burst. A high stall input blocks the clock edge for every register in the block.

The control logic is a two-state machine. In state `ST_IDLE` no burst is active. In state `ST_BURST` a burst is running. The transition `LOAD` (advance low, selected) enters `ST_BURST` from either state and restarts the burst. The transition `STOP` (advance low, deselected) returns to `ST_IDLE`. The transition `STEP` (advance high in `ST_BURST`) stays in `ST_BURST` and advances the beat. `HOLD` (advance high in `ST_IDLE`, or stall high) changes nothing.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `seq_addr` is 0, `burst_on` is 0 and `dir_wr` is 0.
- R2: On an edge with `stall`=0, `adv_ld`=0 and `sel`=1, the block captures `base_addr` and `wr_req`. After that edge `seq_addr` equals the captured address, `burst_on` is 1 and `dir_wr` equals the captured `wr_req`.
- R3: When `order_ilv`=1, the low two bits of `seq_addr` on beat k (k = 0..3 counted from the load) equal start XOR k. A start of 2 gives 2,3,0,1 and a start of 3 gives 3,2,1,0.
- R4: When `order_ilv`=0, the low two bits on beat k equal (start + k) mod 4. A start of 1 gives 1,2,3,0 and a start of 3 gives 3,0,1,2.
- R5: After the fourth beat, a further advance returns the low bits to the start offset, and the sequence repeats.
- R6: While advancing (`adv_ld`=1), `base_addr` is ignored. Bits [ADDR_W-1:2] of `seq_addr` keep the captured value.
- R7: While advancing, `wr_req` is ignored and `dir_wr` holds the captured direction.
- R8: On an edge with `stall`=0, `adv_ld`=0 and `sel`=0, the burst ends. `burst_on` goes to 0 and `seq_addr` holds its value.
- R9: On an edge with `stall`=1, `seq_addr`, `burst_on` and `dir_wr` all keep their values, whatever the other inputs are.
- R10: An advance while no burst is active leaves `seq_addr` unchanged and keeps `burst_on` at 0.
- R11: A load during an active burst restarts the sequence at the new address, with the beat counter cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | 1 blocks the current edge for all state |
| sel | input | 1 | 1 when the chip is selected |
| adv_ld | input | 1 | 0 = load or stop, 1 = advance |
| wr_req | input | 1 | Direction to capture on load, 1 = write |
| order_ilv | input | 1 | Static burst order, 1 = interleaved, 0 = linear |
| base_addr | input | ADDR_W | External base address |
| seq_addr | output | ADDR_W | Current word address |
| burst_on | output | 1 | 1 while a burst is active |
| dir_wr | output | 1 | Captured direction, 1 = write |

## Verification
The stall input can arrive on the same edge as a load, a stop or a step. The bench provokes each of these collisions while a burst is running: a load with a new address under stall, a deselect under stall, and a plain advance under stall. In every case the expected result is that all outputs stay frozen, and that the pending sequence continues correctly from the following unstalled edge. A second collision occurs when a fresh load falls on the cycle where a running burst would otherwise step. The bench judges it by the new address appearing with its start offset at beat 0.

// File: rtl/bas_pkg.sv
package bas_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_t;

endpackage

// File: rtl/bas_ctrl.sv
module bas_ctrl
    import bas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic sel,
    input  logic adv_ld,
    output logic load_en,
    output logic step_en,
    output logic burst_on
);

    seq_state_t state_q, state_d;

    // Next-state decision: LOAD, STOP, STEP or HOLD
    always_comb begin
        state_d = state_q;
        if (!stall) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!adv_ld && sel)       state_d = ST_BURST;
                end
                ST_BURST: begin
                    if (!adv_ld && !sel)      state_d = ST_IDLE;
                    else                      state_d = ST_BURST;
                end
                default:                      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        load_en  = 1'b0;
        step_en  = 1'b0;
        burst_on = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_en = !stall && !adv_ld && sel;
            end
            ST_BURST: begin
                burst_on = 1'b1;
                load_en  = !stall && !adv_ld && sel;
                step_en  = !stall && adv_ld;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bas_hold.sv
module bas_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (cap_en) q <= d;
    end

endmodule

// File: rtl/bas_beat.sv
module bas_beat
    import bas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              step_en,
    input  logic              order_ilv,
    input  logic [BEAT_W-1:0] start_in,
    output logic [BEAT_W-1:0] low_out,
    output logic [BEAT_W-1:0] beat_q
);

    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] ilv_low;
    logic [BEAT_W-1:0] lin_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
        end else if (load_en) begin
            start_q <= start_in;
            beat_q  <= '0;
        end else if (step_en) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    // Interleaved order: each offset bit flips with the matching beat bit
    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
        assign ilv_low[i] = start_q[i] ^ beat_q[i];
    end

    // Linear order: wrapping add inside the burst window
    assign lin_low = start_q + beat_q;

    assign low_out = order_ilv ? ilv_low : lin_low;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              sel,
    input  logic              adv_ld,
    input  logic              wr_req,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] seq_addr,
    output logic              burst_on,
    output logic              dir_wr
);

    localparam int UP_W = ADDR_W - BEAT_W;

    logic              load_en;
    logic              step_en;
    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] low_bits;
    logic [BEAT_W-1:0] beat_q;

    bas_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .sel      (sel),
        .adv_ld   (adv_ld),
        .load_en  (load_en),
        .step_en  (step_en),
        .burst_on (burst_on)
    );

    bas_hold #(.W(UP_W)) u_upper (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (load_en),
        .d      (base_addr[ADDR_W-1:BEAT_W]),
        .q      (upper_q)
    );

    bas_hold #(.W(1)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (load_en),
        .d      (wr_req),
        .q      (dir_wr)
    );

    bas_beat u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .step_en   (step_en),
        .order_ilv (order_ilv),
        .start_in  (base_addr[BEAT_W-1:0]),
        .low_out   (low_bits),
        .beat_q    (beat_q)
    );

    assign seq_addr = {upper_q, low_bits};

endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              sel,
    input logic              adv_ld,
    input logic              wr_req,
    input logic [ADDR_W-1:0] base_addr,
    input logic [ADDR_W-1:0] seq_addr,
    input logic              burst_on,
    input logic              dir_wr,
    input logic [1:0]        beat_q
);

    a_r9_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(seq_addr) && $stable(burst_on) && $stable(dir_wr)));

    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !adv_ld && sel) |=>
            (burst_on && seq_addr == $past(base_addr) && dir_wr == $past(wr_req)));

    // R11: a load always restarts at beat 0
    a_r11_beat_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !adv_ld && sel) |=> (beat_q == 2'd0));

    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !adv_ld && !sel) |=> !burst_on);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv_ld && !burst_on) |=> (!burst_on && $stable(beat_q)));

    // R5: the beat counter steps by one and wraps
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv_ld && burst_on) |=> (burst_on && beat_q == $past(beat_q) + 2'd1));

    a_r6_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ld || stall) |=> $stable(seq_addr[ADDR_W-1:2]));

    a_r7_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ld || stall || !sel) |=> $stable(dir_wr));

endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .sel       (sel),
    .adv_ld    (adv_ld),
    .wr_req    (wr_req),
    .base_addr (base_addr),
    .seq_addr  (seq_addr),
    .burst_on  (burst_on),
    .dir_wr    (dir_wr),
    .beat_q    (beat_q)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;

    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          sel = 1'b0;
    logic          adv_ld = 1'b1;
    logic          wr_req = 1'b0;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] seq_addr;
    logic          burst_on;
    logic          dir_wr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .sel       (sel),
        .adv_ld    (adv_ld),
        .wr_req    (wr_req),
        .order_ilv (order_ilv),
        .base_addr (base_addr),
        .seq_addr  (seq_addr),
        .burst_on  (burst_on),
        .dir_wr    (dir_wr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, settle.
    task automatic cyc(input logic st, input logic s, input logic adv,
                       input logic wr, input logic [AW-1:0] a);
        @(negedge clk);
        stall = st; sel = s; adv_ld = adv; wr_req = wr; base_addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic ilv, input logic wr, input logic [AW-1:0] a);
        @(negedge clk);
        order_ilv = ilv;
        cyc(1'b0, 1'b1, 1'b0, wr, a);
    endtask

    task automatic t_reset;
        chk("R1 addr", seq_addr, 0);
        chk("R1 burst", burst_on, 0);
        chk("R1 dir", dir_wr, 0);
    endtask

    // Runs a load at base then five advances, checking each low value.
    task automatic t_seq(input string req, input logic ilv, input logic [AW-1:0] base,
                         input logic [1:0] e0, input logic [1:0] e1,
                         input logic [1:0] e2, input logic [1:0] e3);
        logic [1:0] exp [4];
        exp = '{e0, e1, e2, e3};
        load(ilv, 1'b0, base);
        chk({req, " R2 load addr"}, seq_addr, base);
        chk("R2 burst_on", burst_on, 1);
        chk("R2 dir", dir_wr, 0);
        for (int k = 1; k < 6; k++) begin
            // garbage address and write request must be ignored (R6, R7)
            cyc(1'b0, k[0], 1'b1, 1'b1, ~base);
            chk({req, " R5 beat"}, seq_addr[1:0], exp[k % 4]);
            chk("R6 upper", seq_addr[AW-1:2], base[AW-1:2]);
            chk("R7 dir", dir_wr, 0);
        end
    endtask

    task automatic t_stop_idle;
        load(1'b0, 1'b1, 17'h0A5A5);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, '0);
        chk("R4 step", seq_addr, 17'h0A5A6);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 17'h1FFFF);
        chk("R8 burst_on", burst_on, 0);
        chk("R8 addr hold", seq_addr, 17'h0A5A6);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 17'h1FFFF);
        chk("R10 burst_on", burst_on, 0);
        chk("R10 addr", seq_addr, 17'h0A5A6);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
        chk("R10 addr again", seq_addr, 17'h0A5A6);
    endtask

    task automatic t_stall;
        load(1'b1, 1'b1, 17'h13570);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 17'h02222);
        chk("R9 load blocked addr", seq_addr, 17'h13570);
        chk("R9 load blocked dir", dir_wr, 1);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk("R9 stop blocked", burst_on, 1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, '0);
        chk("R9 step blocked", seq_addr, 17'h13570);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, '0);
        chk("R9 resume R3", seq_addr, 17'h13571);
    endtask

    task automatic t_reload;
        load(1'b0, 1'b0, 17'h00101);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, '0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, '0);
        chk("R4 two steps", seq_addr, 17'h00103);
        load(1'b0, 1'b1, 17'h1C0C2);
        chk("R11 new addr", seq_addr, 17'h1C0C2);
        chk("R11 new dir", dir_wr, 1);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, '0);
        chk("R11 restart beat", seq_addr, 17'h1C0C3);
    endtask

    initial begin
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_seq("R3 ilv start2", 1'b1, 17'h12342, 2'd2, 2'd3, 2'd0, 2'd1);
        t_seq("R3 ilv start3", 1'b1, 17'h0ABC7, 2'd3, 2'd2, 2'd1, 2'd0);
        t_seq("R4 lin start1", 1'b0, 17'h15555, 2'd1, 2'd2, 2'd3, 2'd0);
        t_seq("R4 lin start3", 1'b0, 17'h0F00B, 2'd3, 2'd0, 2'd1, 2'd2);
        t_stop_idle();
        t_stall();
        t_reload();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule